// File: doc/BRIEF.md
# DTMF Tone-Pair Frequency Decoder

This block turns a dual-tone key press into a 4-bit key code. It has two clean logic-level inputs. One toggles at the frequency of the row tone (697, 770, 852 or 941 Hz). The other toggles at the frequency of the column tone (1209, 1336, 1477 or 1633 Hz). The block does no filtering or limiting.

For each input, the block counts reference-clock cycles between rising edges and compares the count against four acceptance windows, one per standard tone. A tone is qualified once several consecutive periods land in the same window. This rejects short, wandering, voice-like signals while still accepting small frequency errors. While both tones are qualified, the early-steering output is high and the key code register holds the code of the detected pair. Duration checking of the steering signal is left to a downstream block.

Top module: `tone_pair_decoder`

## Requirements
- R1: A synchronous active-high reset clears all qualification state and drives `earlySteer` low and `keyCode` to 0. After reset, `earlySteer` stays low until fresh periods qualify both tones.
- R2: A row-tone period of N reference cycles is accepted for tone f when floor(REF_HZ·40/(f·41)) ≤ N ≤ floor(REF_HZ·40/(f·39)), which is roughly ±2.5 %. A period outside all four row windows makes the row tone invalid.
- R3: The same window rule applies to the column input with the four column frequencies. A column period outside all four windows makes the column tone invalid.
- R4: The first rising edge after reset or after a timeout only starts a measurement. A tone becomes valid only after AVG_PERIODS (default 4) consecutive measured periods fall in the same window, and `earlySteer` cannot rise earlier.
- R5: `earlySteer` is high only while both tones are valid. It falls one cycle after either input delivers a period that is out of window or in a different window.
- R6: If an input shows no rising edge for 3/2 of the longest accepted period of its lowest tone, that tone becomes invalid and `earlySteer` falls.
- R7: Key codes follow the row/column grid. Keys 1–9 map to 1–9, 0 maps to 10, * to 11, # to 12, A/B/C (column 1633 Hz, rows 697/770/852) to 13/14/15, and D (941 Hz with 1633 Hz) to 0.
- R8: `keyCode` is loaded in the same cycle that `earlySteer` is driven high. It keeps its last value after `earlySteer` falls, until the next qualified pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; its rate is REF_HZ |
| rst | input | 1 | Synchronous active-high reset |
| lowToneIn | input | 1 | Limited row-group tone, asynchronous |
| highToneIn | input | 1 | Limited column-group tone, asynchronous |
| earlySteer | output | 1 | High while both tones are valid |
| keyCode | output | 4 | Code of the last qualified tone pair |

## Verification
The bench builds the decoder with REF_HZ = 200000 and AVG_PERIODS = 4. At this rate each tone period spans roughly 120 to 290 clock cycles, so a key qualifies in about 1500 cycles and all sixteen keys fit well inside the run. At this scale the window edges fall on whole-count periods, so the bench can place one tone exactly on the slow edge of the 697 Hz window and another one count beyond it. The scale also lets the bench stop a tone long enough to cross the timeout, and catch `earlySteer` low between the second and fourth qualifying periods.

// File: rtl/tone_pair_pkg.sv
package tone_pair_pkg;

  typedef struct packed {
    logic       rise;
    logic       hit;
    logic [1:0] idx;
    logic       stale;
  } groupMeasT;

  typedef struct packed {
    logic       loadKey;
    logic [1:0] row;
    logic [1:0] col;
  } ctrlStrobeT;

  function automatic int unsigned toneHz(int unsigned grp, int unsigned k);
    int unsigned hz;
    case ({grp[0], k[1:0]})
      3'b000: hz = 697;
      3'b001: hz = 770;
      3'b010: hz = 852;
      3'b011: hz = 941;
      3'b100: hz = 1209;
      3'b101: hz = 1336;
      3'b110: hz = 1477;
      default: hz = 1633;
    endcase
    return hz;
  endfunction

  function automatic int unsigned periodMin(longint unsigned refHz, int unsigned hz);
    longint unsigned q;
    q = (refHz * 64'd40) / (64'(hz) * 64'd41);
    return int'(q);
  endfunction

  function automatic int unsigned periodMax(longint unsigned refHz, int unsigned hz);
    longint unsigned q;
    q = (refHz * 64'd40) / (64'(hz) * 64'd39);
    return int'(q);
  endfunction

  function automatic int unsigned staleLimit(longint unsigned refHz, int unsigned grp);
    return periodMax(refHz, toneHz(grp, 0)) * 3 / 2;
  endfunction

  function automatic logic [3:0] keyCodeOf(logic [1:0] row, logic [1:0] col);
    int unsigned code;
    if (col == 2'd3)      code = (row == 2'd3) ? 0 : 13 + int'(row);
    else if (row == 2'd3) code = (col == 2'd0) ? 11 : (col == 2'd1) ? 10 : 12;
    else                  code = int'(row) * 3 + int'(col) + 1;
    return 4'(code);
  endfunction

endpackage

// File: rtl/tone_pair_datapath.sv
module tone_pair_datapath
  import tone_pair_pkg::*;
#(
  parameter int unsigned REF_HZ = 1000000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            toneIn,
  input  ctrlStrobeT            strobe,
  output groupMeasT [1:0]       meas,
  output logic [3:0]            keyCode
);

  localparam int CNT_W = $clog2(staleLimit(REF_HZ, 0) + 1);

  for (genvar g = 0; g < 2; g++) begin : grp
    localparam int unsigned STALE = staleLimit(REF_HZ, g);

    logic [2:0]       syncQ;
    logic [CNT_W-1:0] cntQ;
    logic [3:0]       winHit;
    logic [1:0]       idxV;
    logic             riseV;

    assign riseV = syncQ[1] & ~syncQ[2];

    for (genvar k = 0; k < 4; k++) begin : win
      localparam int unsigned LO = periodMin(REF_HZ, toneHz(g, k));
      localparam int unsigned HI = periodMax(REF_HZ, toneHz(g, k));
      assign winHit[k] = (cntQ >= CNT_W'(LO)) && (cntQ <= CNT_W'(HI));
    end

    always_comb begin
      idxV = 2'd0;
      for (int k = 3; k >= 0; k--) begin
        if (winHit[k]) idxV = 2'(k);
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        syncQ <= '0;
        cntQ  <= '0;
      end else begin
        syncQ <= {syncQ[1:0], toneIn[g]};
        if (riseV)                       cntQ <= CNT_W'(1);
        else if (cntQ != CNT_W'(STALE))  cntQ <= cntQ + CNT_W'(1);
      end
    end

    assign meas[g] = '{rise: riseV, hit: |winHit, idx: idxV,
                       stale: (cntQ == CNT_W'(STALE))};

    // R6: the period counter saturates at the stale limit
    assert_cnt_cap_R6: assert property (@(posedge clk) disable iff (rst)
      cntQ <= CNT_W'(STALE));
  end

  always_ff @(posedge clk) begin
    if (rst)                 keyCode <= 4'd0;
    else if (strobe.loadKey) keyCode <= keyCodeOf(strobe.row, strobe.col);
  end

  // R8: the key register changes only on a load strobe
  assert_key_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadKey |=> $stable(keyCode));

  // R1: reset leaves the key code at zero
  assert_key_reset_R1: assert property (@(posedge clk)
    rst |=> (keyCode == 4'd0));

endmodule

// File: rtl/tone_pair_control.sv
module tone_pair_control
  import tone_pair_pkg::*;
#(
  parameter int unsigned AVG_PERIODS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  groupMeasT [1:0] meas,
  output ctrlStrobeT      strobe,
  output logic            earlySteer
);

  localparam int RUN_W = $clog2(AVG_PERIODS + 1);

  logic [1:0]       armedQ, armedN;
  logic [RUN_W-1:0] runQ [2];
  logic [RUN_W-1:0] runN [2];
  logic [1:0]       idxQ [2];
  logic [1:0]       idxN [2];
  logic [1:0]       validN;
  logic             steerN;

  always_comb begin
    for (int g = 0; g < 2; g++) begin
      armedN[g] = armedQ[g];
      runN[g]   = runQ[g];
      idxN[g]   = idxQ[g];
      if (meas[g].rise) begin
        if (!armedQ[g]) begin
          armedN[g] = 1'b1;
          runN[g]   = '0;
        end else if (!meas[g].hit) begin
          runN[g] = '0;
        end else if ((runQ[g] != '0) && (meas[g].idx == idxQ[g])) begin
          if (runQ[g] != RUN_W'(AVG_PERIODS)) runN[g] = runQ[g] + RUN_W'(1);
        end else begin
          runN[g] = RUN_W'(1);
          idxN[g] = meas[g].idx;
        end
      end else if (meas[g].stale) begin
        armedN[g] = 1'b0;
        runN[g]   = '0;
      end
      validN[g] = (runN[g] == RUN_W'(AVG_PERIODS));
    end
    steerN = &validN;
  end

  assign strobe = '{loadKey: steerN, row: idxN[0], col: idxN[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      armedQ     <= '0;
      runQ[0]    <= '0;
      runQ[1]    <= '0;
      idxQ[0]    <= '0;
      idxQ[1]    <= '0;
      earlySteer <= 1'b0;
    end else begin
      armedQ     <= armedN;
      runQ[0]    <= runN[0];
      runQ[1]    <= runN[1];
      idxQ[0]    <= idxN[0];
      idxQ[1]    <= idxN[1];
      earlySteer <= steerN;
    end
  end

  // R1: reset drops early steering
  assert_steer_reset_R1: assert property (@(posedge clk)
    rst |=> !earlySteer);

  // R4: steering can only rise right after a measured edge
  assert_rise_on_edge_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(earlySteer) |-> $past(meas[0].rise || meas[1].rise));

  for (genvar g = 0; g < 2; g++) begin : chk
    // R6: a stale input forces steering low next cycle
    assert_stale_drop_R6: assert property (@(posedge clk) disable iff (rst)
      meas[g].stale |=> !earlySteer);
    // R5: an out-of-window period forces steering low next cycle
    assert_bad_period_R5: assert property (@(posedge clk) disable iff (rst)
      (meas[g].rise && !meas[g].hit) |=> !earlySteer);
  end

endmodule

// File: rtl/tone_pair_decoder.sv
module tone_pair_decoder
  import tone_pair_pkg::*;
#(
  parameter int unsigned REF_HZ      = 1000000,
  parameter int unsigned AVG_PERIODS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lowToneIn,
  input  logic       highToneIn,
  output logic       earlySteer,
  output logic [3:0] keyCode
);

  groupMeasT [1:0] meas;
  ctrlStrobeT      strobe;

  tone_pair_datapath #(.REF_HZ(REF_HZ)) dp (
    .clk     (clk),
    .rst     (rst),
    .toneIn  ({highToneIn, lowToneIn}),
    .strobe  (strobe),
    .meas    (meas),
    .keyCode (keyCode)
  );

  tone_pair_control #(.AVG_PERIODS(AVG_PERIODS)) ctl (
    .clk        (clk),
    .rst        (rst),
    .meas       (meas),
    .strobe     (strobe),
    .earlySteer (earlySteer)
  );

endmodule

// File: tb/tone_pair_decoder_test.sv
module tone_pair_decoder_test;

  localparam int REF = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lowToneIn = 1'b0;
  logic       highToneIn = 1'b0;
  logic       earlySteer;
  logic [3:0] keyCode;

  int loHalf = 0;
  int hiHalf = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  // row Hz, column Hz, expected code; keys 1 2 3 A 4 5 6 B 7 8 9 C * 0 # D
  localparam int VEC_LO [16] = '{697,697,697,697,770,770,770,770,
                                 852,852,852,852,941,941,941,941};
  localparam int VEC_HI [16] = '{1209,1336,1477,1633,1209,1336,1477,1633,
                                 1209,1336,1477,1633,1209,1336,1477,1633};
  localparam int VEC_KEY[16] = '{1,2,3,13,4,5,6,14,7,8,9,15,11,10,12,0};

  always #2 clk = ~clk;

  tone_pair_decoder #(.REF_HZ(REF), .AVG_PERIODS(4)) uut (
    .clk(clk), .rst(rst), .lowToneIn(lowToneIn), .highToneIn(highToneIn),
    .earlySteer(earlySteer), .keyCode(keyCode)
  );

  initial forever begin
    if (loHalf == 0) begin lowToneIn = 1'b0; @(negedge clk); end
    else begin repeat (loHalf) @(negedge clk); lowToneIn = ~lowToneIn; end
  end

  initial forever begin
    if (hiHalf == 0) begin highToneIn = 1'b0; @(negedge clk); end
    else begin repeat (hiHalf) @(negedge clk); highToneIn = ~highToneIn; end
  end

  function automatic int halfOf(int hz);
    return REF / (2 * hz);
  endfunction

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expectOut(string req, int es, int key);
    check(earlySteer == es, req, int'(earlySteer), es);
    if (key >= 0) check(keyCode == 4'(key), req, int'(keyCode), key);
  endtask

  task automatic silence();
    loHalf = 0; hiHalf = 0;
    waitCyc(1200);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finishRun();
    end
  end

  initial begin
    waitCyc(5);
    rst = 1'b0;
    waitCyc(2);
    expectOut("R1 reset state", 0, 0);

    // table walk: every key, then release; R7 mapping, R8 hold, R6 timeout
    for (int i = 0; i < 16; i++) begin
      loHalf = halfOf(VEC_LO[i]);
      hiHalf = halfOf(VEC_HI[i]);
      waitCyc(2600);
      expectOut("R7 key map", 1, VEC_KEY[i]);
      silence();
      expectOut("R6/R8 release holds key", 0, VEC_KEY[i]);
    end

    // R4: not valid after only two periods, valid after four
    loHalf = halfOf(697); hiHalf = halfOf(1209);
    waitCyc(950);
    expectOut("R4 early count", 0, -1);
    waitCyc(650);
    expectOut("R4 four periods", 1, 1);
    silence();

    // R5: a single tone never steers
    loHalf = halfOf(852);
    waitCyc(2600);
    expectOut("R5 row only", 0, 1);
    silence();

    // R2: row tone too high in frequency (period 200 cycles)
    loHalf = 100; hiHalf = halfOf(1336);
    waitCyc(2600);
    expectOut("R2 row off window", 0, 1);
    silence();

    // R3: column tone between windows (period 156 cycles)
    loHalf = halfOf(770); hiHalf = 78;
    waitCyc(2600);
    expectOut("R3 column off window", 0, 1);
    silence();

    // R2: period 294 sits on the slow edge of the 697 Hz window
    loHalf = 147; hiHalf = halfOf(1336);
    waitCyc(2800);
    expectOut("R2 window edge accepted", 1, 2);
    silence();

    // R2: period 296 is just outside it
    loHalf = 148; hiHalf = halfOf(1336);
    waitCyc(2800);
    expectOut("R2 window edge rejected", 0, 2);
    silence();

    // R5: column changes window while steering; drop, then new key
    loHalf = halfOf(770); hiHalf = halfOf(1336);
    waitCyc(2600);
    expectOut("R5 before switch", 1, 5);
    hiHalf = halfOf(1477);
    waitCyc(220);
    expectOut("R5 drop on switch", 0, 5);
    waitCyc(1000);
    expectOut("R8 reload after switch", 1, 6);

    // R1: reset in the middle of a qualified pair
    @(negedge clk); rst = 1'b1;
    waitCyc(2);
    rst = 1'b0;
    waitCyc(1);
    expectOut("R1 reset mid-key", 0, 0);
    waitCyc(300);
    expectOut("R1 requalify needed", 0, 0);
    waitCyc(2000);
    expectOut("R1 requalified", 1, 6);
    silence();

    done = 1'b1;
    finishRun();
  end

endmodule